// File: doc/BRIEF.md
# HDLC Receive Block Pool Controller

This block stands between the byte stream of an HDLC receiver and a host processor. The receiver delivers data bytes, and at the close of each frame one status byte. The controller places both kinds of byte in one circular store of 64 entries. A tag bit on each entry marks the status bytes. The host sees the store one block at a time. A block is either a full chunk of the programmed size taken from the current frame, or the final piece of a frame, which ends with its status byte. The controller signals each kind of block with its own interrupt line.

The host reads the block byte by byte through a read strobe, then acknowledges it. Only the acknowledge returns the entries to the free pool. Only one block is offered at a time. Several short frames can wait in the store together, and the host receives them in the order they arrived. A byte counter tells the host how many bytes the current frame has delivered so far. When a frame ends, the host uses this counter to learn the length of the last piece.

Top module: `hdlc_rx_pool`

## Requirements
- R1: The size field `cfg_blk` is stored when `cfg_we` is high. Its codes give these block sizes: 2'b11 = 4 bytes, 2'b10 = 8 bytes, 2'b01 = 16 bytes, 2'b00 = 32 bytes. Reset selects 16.
- R2: When no interrupt is pending, the controller checks the oldest stored entries. If at least one block's worth is stored and none of the first block-size entries is a status byte, it raises `irq_pool`. That block then holds exactly block-size bytes. `host_data` shows them in arrival order, and each `host_rd` pulse steps to the next byte.
- R3: When no interrupt is pending and a status byte lies within the first block-size stored entries, the controller raises `irq_end`. That block covers every entry up to and including the status byte, so the status byte is the last byte the host reads.
- R4: Reading never frees space. A pending interrupt stays asserted until `host_ack`, however many reads occur. The entries of the block are released only by the acknowledge.
- R5: The block size in force is fixed at the moment an interrupt is raised. A change made while a block is pending applies only to blocks evaluated after the acknowledge.
- R6: Several complete frames may be stored at once. They are delivered in arrival order, each frame ending with its own `irq_end` block.
- R7: `byte_cnt` changes only when an interrupt is raised. For the first block of a frame it becomes that block's length. For each later block of the same frame it grows by that block's length, and the length of the final block includes the status byte. It holds its value until the next frame's first block is raised.
- R8: A data byte is stored only while at least two entries are free. A data byte that arrives otherwise is dropped and marks the frame as overflowed. The status byte of an overflowed frame is stored with bit 7 forced to 1. A status byte that finds no free entry is dropped, and with it the whole frame.
- R9: At most one of `irq_pool` and `irq_end` is high at any time. A `host_ack` given while neither is high has no effect.
- R10: After reset the store is empty, both interrupts are low and `byte_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receiver byte strobe |
| rx_is_status | input | 1 | The strobed byte is the frame's status byte |
| rx_byte | input | 8 | Received byte |
| cfg_we | input | 1 | Write strobe for the block-size field |
| cfg_blk | input | 2 | Block-size code (see R1) |
| host_rd | input | 1 | Host read strobe; advances within the pending block |
| host_ack | input | 1 | Host acknowledge; releases the pending block |
| host_data | output | 8 | Byte at the host's current read position |
| irq_pool | output | 1 | Full block of frame data pending |
| irq_end | output | 1 | Final block of a frame pending |
| byte_cnt | output | RBW | Bytes delivered so far for the current frame |

## Verification
Frames are sent in several shapes. A long frame checks that full blocks are offered ahead of the tail. A burst of short frames, including one with no data bytes at all, checks delivery order and blocks made of the status byte alone. Frames near each block size check that the boundary between a full block and a final block falls where the status byte lies. The size is changed while a block is pending to show that the pending block keeps its length and only later blocks change. A 70-byte frame overfills the store, and an extra frame is written while a block has been read but not yet acknowledged. Together these show that dropped bytes set the overflow mark, that a status byte with no room removes its frame, and that reads alone free nothing.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POOL = 2'd1,
        ST_END  = 2'd2
    } rxp_state_e;

    typedef struct packed {
        logic       stat;
        logic [7:0] val;
    } rxp_word_t;

    // Block length in bytes for each size code.
    function automatic int unsigned blk_bytes(input logic [1:0] code);
        case (code)
            2'b11:   return 4;
            2'b10:   return 8;
            2'b01:   return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/rxp_store.sv
module rxp_store
    import rxp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  rxp_word_t          wword,
    input  logic [AW-1:0]      raddr,
    output rxp_word_t          rword,
    output logic [DEPTH-1:0]   stat_flags
);

    rxp_word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wword;
        end
    end

    assign rword = mem_q[raddr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
        assign stat_flags[g] = mem_q[g].stat;
    end

endmodule

// File: rtl/rxp_scan.sv
module rxp_scan #(
    parameter int DEPTH  = 64,
    parameter int MAXBLK = 32,
    parameter int AW     = $clog2(DEPTH),
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]    base,
    input  logic [CW-1:0]    fill,
    input  logic [CW-1:0]    blk,
    input  logic [DEPTH-1:0] flags,
    output logic             hit_any,
    output logic [CW-1:0]    hit_pos,
    output logic             blk_full
);

    logic [MAXBLK-1:0] win;

    // One window slot per possible block position, counted from the oldest entry.
    for (genvar g = 0; g < MAXBLK; g++) begin : g_win
        logic [AW-1:0] idx;
        assign idx    = base + AW'(g);
        assign win[g] = flags[idx] && (CW'(g) < fill) && (CW'(g) < blk);
    end

    always_comb begin
        hit_any = 1'b0;
        hit_pos = '0;
        for (int i = MAXBLK - 1; i >= 0; i--) begin
            if (win[i]) begin
                hit_any = 1'b1;
                hit_pos = CW'(i);
            end
        end
    end

    assign blk_full = (fill >= blk);

endmodule

// File: rtl/rxp_ctrl.sv
module rxp_ctrl
    import rxp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int RBW   = 12,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic            wr_stat,
    input  logic [7:0]      wr_data,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_bsz,
    input  logic            rd_en,
    input  logic            ack,
    input  logic            hit_any,
    input  logic [CW-1:0]   hit_pos,
    input  logic            blk_full,
    output logic [CW-1:0]   blk,
    output logic [AW-1:0]   base,
    output logic [CW-1:0]   fill,
    output logic            we,
    output logic [AW-1:0]   waddr,
    output rxp_word_t       wword,
    output logic [AW-1:0]   raddr,
    output logic            irq_pool,
    output logic            irq_end,
    output logic [RBW-1:0]  rbc
);

    typedef struct packed {
        rxp_state_e       st;
        logic [AW-1:0]    base;
        logic [CW-1:0]    fill;
        logic [CW-1:0]    len;
        logic [CW-1:0]    off;
        logic [RBW-1:0]   rbc;
        logic             newfrm;
        logic             ovf;
        logic [1:0]       cfg;
    } ctrl_t;

    ctrl_t         q, d;
    logic [CW-1:0] free_n;
    logic [CW-1:0] dec;

    assign blk = CW'(blk_bytes(q.cfg));

    always_comb begin
        d      = q;
        we     = 1'b0;
        wword  = '0;
        dec    = '0;
        free_n = CW'(DEPTH) - q.fill;

        // Write side: one entry is kept back for the frame's status byte.
        if (wr_valid) begin
            if (!wr_stat) begin
                if (free_n >= CW'(2)) begin
                    we    = 1'b1;
                    wword = '{stat: 1'b0, val: wr_data};
                end else begin
                    d.ovf = 1'b1;
                end
            end else begin
                if (q.fill < CW'(DEPTH)) begin
                    we    = 1'b1;
                    wword = '{stat: 1'b1, val: {q.ovf | wr_data[7], wr_data[6:0]}};
                end
                d.ovf = 1'b0;
            end
        end

        if (cfg_we) begin
            d.cfg = cfg_bsz;
        end

        // Host side: evaluate one block, hold it until acknowledged.
        case (q.st)
            ST_IDLE: begin
                if (hit_any || blk_full) begin
                    d.st     = hit_any ? ST_END : ST_POOL;
                    d.len    = hit_any ? (hit_pos + CW'(1)) : blk;
                    d.off    = '0;
                    d.rbc    = q.newfrm ? RBW'(d.len) : (q.rbc + RBW'(d.len));
                    d.newfrm = 1'b0;
                end
            end
            default: begin
                if (rd_en && (q.off < q.len)) begin
                    d.off = q.off + CW'(1);
                end
                if (ack) begin
                    dec    = q.len;
                    d.base = q.base + AW'(q.len);
                    d.st   = ST_IDLE;
                    if (q.st == ST_END) begin
                        d.newfrm = 1'b1;
                    end
                end
            end
        endcase

        d.fill = q.fill + CW'(we) - dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.base   <= '0;
            q.fill   <= '0;
            q.len    <= '0;
            q.off    <= '0;
            q.rbc    <= '0;
            q.newfrm <= 1'b1;
            q.ovf    <= 1'b0;
            q.cfg    <= 2'b01;
        end else begin
            q <= d;
        end
    end

    assign base     = q.base;
    assign fill     = q.fill;
    assign waddr    = q.base + AW'(q.fill);
    assign raddr    = q.base + AW'(q.off);
    assign irq_pool = (q.st == ST_POOL);
    assign irq_end  = (q.st == ST_END);
    assign rbc      = q.rbc;

    // R8: the store never holds more than its capacity
    a_r8_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.fill <= CW'(DEPTH));

    // R4: entries leave the store only through an acknowledge of a pending block
    a_r4_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fill < $past(q.fill)) |-> $past(ack && (q.st != ST_IDLE)));

    // R9: a pending block stays pending until acknowledged
    a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.st) != ST_IDLE) && !$past(ack)) |-> (q.st == $past(q.st)));

    // R2: a full block takes the size in force when it was raised
    a_r2_pool_len: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_POOL) && ($past(q.st) == ST_IDLE)) |-> (q.len == $past(blk)));

    // R3: a final block never exceeds the size in force
    a_r3_end_len: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_END) && ($past(q.st) == ST_IDLE)) |-> (q.len <= $past(blk)));

    // R5: the length of a pending block is frozen
    a_r5_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != ST_IDLE) && ($past(q.st) != ST_IDLE)) |-> $stable(q.len));

    // R7: the byte counter moves only when a block is raised
    a_r7_count_on_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rbc != $past(q.rbc)) |-> (($past(q.st) == ST_IDLE) && (q.st != ST_IDLE)));

endmodule

// File: rtl/hdlc_rx_pool.sv
module hdlc_rx_pool
    import rxp_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MAXBLK = 32,
    parameter int RBW    = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_valid,
    input  logic           rx_is_status,
    input  logic [7:0]     rx_byte,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_blk,
    input  logic           host_rd,
    input  logic           host_ack,
    output logic [7:0]     host_data,
    output logic           irq_pool,
    output logic           irq_end,
    output logic [RBW-1:0] byte_cnt
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    blk;
    logic [AW-1:0]    base;
    logic [CW-1:0]    fill;
    logic             we;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    rxp_word_t        wword;
    rxp_word_t        rword;
    logic [DEPTH-1:0] flags;
    logic             hit_any;
    logic [CW-1:0]    hit_pos;
    logic             blk_full;

    rxp_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk        (clk),
        .we         (we),
        .waddr      (waddr),
        .wword      (wword),
        .raddr      (raddr),
        .rword      (rword),
        .stat_flags (flags)
    );

    rxp_scan #(.DEPTH(DEPTH), .MAXBLK(MAXBLK), .AW(AW), .CW(CW)) u_scan (
        .base     (base),
        .fill     (fill),
        .blk      (blk),
        .flags    (flags),
        .hit_any  (hit_any),
        .hit_pos  (hit_pos),
        .blk_full (blk_full)
    );

    rxp_ctrl #(.DEPTH(DEPTH), .RBW(RBW), .AW(AW), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (rx_valid),
        .wr_stat  (rx_is_status),
        .wr_data  (rx_byte),
        .cfg_we   (cfg_we),
        .cfg_bsz  (cfg_blk),
        .rd_en    (host_rd),
        .ack      (host_ack),
        .hit_any  (hit_any),
        .hit_pos  (hit_pos),
        .blk_full (blk_full),
        .blk      (blk),
        .base     (base),
        .fill     (fill),
        .we       (we),
        .waddr    (waddr),
        .wword    (wword),
        .raddr    (raddr),
        .irq_pool (irq_pool),
        .irq_end  (irq_end),
        .rbc      (byte_cnt)
    );

    assign host_data = rword.val;

endmodule

// File: tb/sim_hdlc_rx_pool.sv
`timescale 1ns/1ps
module sim_hdlc_rx_pool;

    localparam int DEPTH = 64;
    localparam int RBW   = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rx_valid = 1'b0;
    logic           rx_is_status = 1'b0;
    logic [7:0]     rx_byte = '0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_blk = '0;
    logic           host_rd = 1'b0;
    logic           host_ack = 1'b0;
    logic [7:0]     host_data;
    logic           irq_pool;
    logic           irq_end;
    logic [RBW-1:0] byte_cnt;

    int nchk = 0;
    int nfail = 0;

    // Scoreboard state: expected store contents and acceptance model.
    logic [8:0] expq[$];
    int  mcnt = 0;
    bit  movf = 0;
    int  racc = 0;
    bit  newf = 1;

    always #4 clk = ~clk;

    hdlc_rx_pool #(.DEPTH(DEPTH), .MAXBLK(32), .RBW(RBW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_is_status (rx_is_status),
        .rx_byte      (rx_byte),
        .cfg_we       (cfg_we),
        .cfg_blk      (cfg_blk),
        .host_rd      (host_rd),
        .host_ack     (host_ack),
        .host_data    (host_data),
        .irq_pool     (irq_pool),
        .irq_end      (irq_end),
        .byte_cnt     (byte_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one receiver byte, with the expected-store model updated per R8.
    task automatic wr(input logic [7:0] dv, input bit st);
        @(negedge clk);
        rx_valid     = 1'b1;
        rx_byte      = dv;
        rx_is_status = st;
        if (!st) begin
            if (DEPTH - mcnt >= 2) begin
                expq.push_back({1'b0, dv});
                mcnt++;
            end else begin
                movf = 1;
            end
        end else begin
            if (mcnt < DEPTH) begin
                expq.push_back({1'b1, movf | dv[7], dv[6:0]});
                mcnt++;
            end
            movf = 0;
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic frame(input int n, input logic [7:0] seed, input logic [7:0] stv);
        for (int i = 0; i < n; i++) begin
            wr(seed + 8'(i), 1'b0);
        end
        wr(stv, 1'b1);
    endtask

    task automatic set_cfg(input logic [1:0] v);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_blk = v;
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    // Monitor: waits for a block, predicts its kind and length, pops and compares.
    task automatic drain(input int n, input string tag, input bit extra = 0,
                         input int newcfg = -1, input bit hold = 0);
        bit got = 0;
        int k = -1;
        bit me;
        int len;
        logic [8:0] e;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (irq_pool || irq_end) begin
                got = 1;
                break;
            end
        end
        chk(got, {tag, " block raised"}, 0, 1);
        if (!got) return;
        for (int i = 0; i < n && i < expq.size(); i++) begin
            if (expq[i][8]) begin
                k = i;
                break;
            end
        end
        me  = (k >= 0);
        len = me ? k + 1 : n;
        chk((irq_end == me) && (irq_pool == !me), {tag, " R2/R3 interrupt kind"},
            int'({irq_pool, irq_end}), me ? 1 : 2);
        racc = newf ? len : racc + len;
        newf = 0;
        chk(int'(byte_cnt) == racc, {tag, " R7 byte count"}, int'(byte_cnt), racc);
        for (int i = 0; i < len; i++) begin
            e = expq.pop_front();
            chk(host_data == e[7:0], {tag, " data byte"}, int'(host_data), int'(e[7:0]));
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
        end
        if (hold) begin
            repeat (10) @(negedge clk);
            chk((irq_pool == !me) && (irq_end == me), {tag, " R4 pending after reads"},
                int'({irq_pool, irq_end}), me ? 1 : 2);
        end
        if (extra) begin
            frame(1, 8'h77, 8'h11);
        end
        if (newcfg >= 0) begin
            set_cfg(2'(newcfg));
        end
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        mcnt -= len;
        if (me) newf = 1;
        chk(!irq_pool && !irq_end, {tag, " R9 cleared by ack"}, int'({irq_pool, irq_end}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!irq_pool && !irq_end, "R10 interrupts after reset", int'({irq_pool, irq_end}), 0);
        chk(byte_cnt == 0, "R10 count after reset", int'(byte_cnt), 0);

        // R9: acknowledge with nothing pending
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(!irq_pool && !irq_end, "R9 idle ack ignored", int'({irq_pool, irq_end}), 0);

        // R1 default size 16, R2 full block, R4 reads hold, R3 tail
        frame(20, 8'h10, 8'h05);
        drain(16, "R1 default", 0, -1, 1);
        drain(16, "R3 tail");

        // R6: several short frames queued, size 4
        set_cfg(2'b11);
        frame(3, 8'h40, 8'h01);
        frame(6, 8'h50, 8'h02);
        frame(0, 8'h00, 8'h03);
        drain(4, "R6 first");
        drain(4, "R6 second");
        drain(4, "R6 second tail");
        drain(4, "R6 empty frame");

        // R5: size change while a block is pending
        frame(12, 8'h60, 8'h04);
        drain(4, "R5 before", 0, 1);
        drain(16, "R5 after");

        // R1: codes for 32 and 8
        set_cfg(2'b00);
        frame(40, 8'h80, 8'h06);
        drain(32, "R1 size32");
        drain(32, "R1 size32 tail");
        set_cfg(2'b10);
        frame(9, 8'hC0, 8'h07);
        drain(8, "R1 size8");
        drain(8, "R1 size8 tail");

        // R8: overflow, status without room, reads free nothing
        set_cfg(2'b00);
        frame(70, 8'h00, 8'h2A);
        frame(0, 8'h00, 8'h33);
        drain(32, "R8 first", 1);
        drain(32, "R8 tail");
        repeat (20) @(negedge clk);
        chk(!irq_pool && !irq_end, "R8 dropped frames absent", int'({irq_pool, irq_end}), 0);
        chk(expq.size() == 0, "R4 scoreboard empty", expq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule